// File: doc/BRIEF.md
# Transport-Triggered Move Processor Core

This block is a compact processor core in which every action is a data transport. Each instruction word carries four move slots and one 32-bit long-immediate field. In a single cycle each slot copies one value from a source socket to a destination socket over its own bus. The possible sources are a register-file read port, the ALU result register, a short or long immediate, and the link value (address of the next instruction). The possible destinations are a register-file write port, the ALU operand or trigger ports, a boolean guard register, the jump or branch control ports, and an output port.

Arithmetic is started only as a side effect of a move. A move to the operand port just latches a value. A move to a trigger port supplies the second operand, selects the operation through the low destination bits, and starts the ALU. A later move then fetches the result. Control flow also uses moves: an absolute jump, a PC-relative branch, and a call that saves the link value in a register while branching to the target. The instruction memory is a plain array that the environment fills while the core is held in reset. Execution begins at address 0 when reset is released.

Top module: `tta_core`

## Requirements
- R1: After a synchronous active-low reset, the PC is 0, `out_valid` is 0, all boolean registers are 0, the ALU operand and result registers are 0 and all 16 general registers are 0. Execution starts at address 0 on the first clock edge with `rst_n` high.
- R2: Slot s occupies bits [17*s+16 : 17*s] of the 100-bit instruction. Inside a slot, the destination is in bits [5:0], the source in [11:6], the immediate flag in [12] and the guard in [16:13]. Bits [99:68] hold the long immediate. All four slots read their sources before any write of the same instruction takes effect.
- R3: When the immediate flag is 1, the 6-bit source field is sign-extended to 32 bits and that value is moved.
- R4: When the immediate flag is 0, source code 0x11 moves the long-immediate field, source 0x10 moves the ALU result, source 0x12 moves the address of the next instruction (PC+1), and any other source code above 0x0F moves 0.
- R5: Source and destination codes 0x00–0x0F address registers r0–r15. A register write lands at the end of the cycle, so a read of the same register in the same instruction returns the old value.
- R6: Destination 0x10 only latches the ALU operand. Destination 0x18+op triggers the ALU with the moved value as second operand. The op codes are: 0 add, 1 operand minus trigger, 2 and, 3 or, 4 xor, 5 equal (1/0), 6 unsigned less-than (1/0), 7 shift operand left by trigger[4:0]. If the operand and the trigger are moved in the same instruction, the new operand is used.
- R7: The ALU result is readable in the instruction after the trigger. It keeps its value until the next trigger, and an operand-only move leaves it unchanged. A result read in the triggering instruction returns the previous result.
- R8: Guard code 0000 means always. Code 1xxx executes the move only if boolean register xxx is 1. Every other code never executes. A move whose guard is false has no effect. Destinations 0x20–0x27 set boolean register b0–b7 to 1 when the value is non-zero and to 0 otherwise. Guards read the boolean values held before the instruction.
- R9: Destination 0x28 loads the moved value into the PC (jump). Destination 0x29 sets the next PC to the current instruction's address plus the moved value (branch). Without such a move the next PC is PC+1.
- R10: A call is formed by moving source 0x12 into a register and a displacement to 0x29 in the same instruction. A later jump through that register returns to the instruction after the call.
- R11: When several executing slots of one instruction write the same destination, the highest-numbered slot wins. Jump and branch count as one control destination for this rule.
- R12: A move to destination 0x2A raises `out_valid` for exactly the following cycle, with the moved value on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Instruction memory write enable |
| imem_addr | input | PC_W (6) | Instruction memory write address |
| imem_wdata | input | 100 | Instruction word to write |
| pc | output | PC_W (6) | Address of the instruction executing this cycle |
| out_valid | output | 1 | One-cycle pulse after a move to the output port |
| out_data | output | 32 | Value of the last output-port move |

## Verification
The only visible state is the output port and the PC, so a wrong internal state shows up in a later output move. A corrupted register, boolean register or ALU result appears in the first output that reads it, usually one or two instructions later. Every test program is therefore built so that each result passes through the output port. A control fault, such as a wrong branch base, a lost link value or a wrong winner among conflicting slots, sends the PC to filler instructions. These filler instructions emit unexpected values, so the fault shows in the output sequence, its cycle numbers and the final PC within a few cycles.

// File: rtl/tta_pkg.sv
// Package: shared widths, socket codes and the move record for the core.
// Assumes four slots of 17 bits plus a 32-bit long immediate per instruction.
package tta_pkg;
    localparam int DATA_W   = 32;
    localparam int NSLOT    = 4;
    localparam int NREG     = 16;
    localparam int NBOOL    = 8;
    localparam int GRD_W    = 4;
    localparam int SRC_W    = 6;
    localparam int DST_W    = 6;
    localparam int SLOT_W   = GRD_W + 1 + SRC_W + DST_W;
    localparam int INSTR_W  = NSLOT * SLOT_W + DATA_W;
    localparam int RADDR_W  = $clog2(NREG);
    localparam int BSEL_W   = $clog2(NBOOL);

    // Source socket codes (immediate flag clear)
    localparam logic [SRC_W-1:0] SRC_RESULT = 6'h10;
    localparam logic [SRC_W-1:0] SRC_LIMM   = 6'h11;
    localparam logic [SRC_W-1:0] SRC_LINK   = 6'h12;

    // Destination socket codes
    localparam logic [DST_W-1:0] DST_OPND   = 6'h10;
    localparam logic [2:0]       DST_TRIG_H = 3'b011;   // 0x18..0x1F
    localparam logic [2:0]       DST_BOOL_H = 3'b100;   // 0x20..0x27
    localparam logic [DST_W-1:0] DST_JUMP   = 6'h28;
    localparam logic [DST_W-1:0] DST_BRANCH = 6'h29;
    localparam logic [DST_W-1:0] DST_OUT    = 6'h2A;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR  = 3'd3,
        OP_XOR = 3'd4, OP_EQ  = 3'd5, OP_LTU = 3'd6, OP_SHL = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic               en;
        logic [DST_W-1:0]   dst;
        logic [DATA_W-1:0]  val;
    } move_t;
endpackage

// File: rtl/tta_imem.sv
// Instruction store: synchronous write, asynchronous read at the PC.
// Assumes contents are loaded by the environment before execution starts.
module tta_imem
    import tta_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [INSTR_W-1:0] wdata,
    input  logic [AW-1:0]      raddr,
    output logic [INSTR_W-1:0] rdata
);
    logic [INSTR_W-1:0] mem [DEPTH];

    // Write port: store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: current instruction word.
    assign rdata = mem[raddr];
endmodule

// File: rtl/tta_slot_unit.sv
// One move slot: splits the fields, evaluates the guard and selects the
// source value. Assumes register read data arrives combinationally.
module tta_slot_unit
    import tta_pkg::*;
(
    input  logic [SLOT_W-1:0]  slot,
    input  logic [DATA_W-1:0]  limm,
    input  logic [DATA_W-1:0]  link,
    input  logic [DATA_W-1:0]  alu_res,
    input  logic [NBOOL-1:0]   bools,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic [RADDR_W-1:0] rf_raddr,
    output move_t              mv
);
    logic [GRD_W-1:0] grd;
    logic             imm;
    logic [SRC_W-1:0] src;
    logic [DST_W-1:0] dst;
    logic             grd_ok;
    logic [DATA_W-1:0] val;

    assign {grd, imm, src, dst} = slot;
    assign rf_raddr = src[RADDR_W-1:0];

    // Guard: 0000 always, 1xxx boolean register, anything else never.
    always_comb begin
        if (grd == '0) begin
            grd_ok = 1'b1;
        end else if (grd[GRD_W-1]) begin
            grd_ok = bools[grd[BSEL_W-1:0]];
        end else begin
            grd_ok = 1'b0;
        end
    end

    // Source mux: short immediate or a socket chosen by the source code.
    always_comb begin
        if (imm) begin
            val = {{(DATA_W-SRC_W){src[SRC_W-1]}}, src};
        end else if (src[SRC_W-1:RADDR_W] == '0) begin
            val = rf_rdata;
        end else begin
            case (src)
                SRC_RESULT: val = alu_res;
                SRC_LIMM:   val = limm;
                SRC_LINK:   val = link;
                default:    val = '0;
            endcase
        end
    end

    assign mv = '{en: grd_ok, dst: dst, val: val};
endmodule

// File: rtl/tta_regfile.sv
// General register file: one read and one write port per move bus.
// Assumes the highest-numbered slot wins when several write one register.
module tta_regfile
    import tta_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RADDR_W-1:0] raddr [NSLOT],
    output logic [DATA_W-1:0]  rdata [NSLOT],
    input  move_t              mv    [NSLOT]
);
    logic [DATA_W-1:0] regs [NREG];

    for (genvar p = 0; p < NSLOT; p++) begin : g_rd
        assign rdata[p] = regs[raddr[p]];
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic              wen;
        logic [DATA_W-1:0] wval;

        // Write select: scan slots upward so the last match wins.
        always_comb begin
            wen  = 1'b0;
            wval = regs[r];
            for (int s = 0; s < NSLOT; s++) begin
                if (mv[s].en && mv[s].dst == DST_W'(r)) begin
                    wen  = 1'b1;
                    wval = mv[s].val;
                end
            end
        end

        // Storage: clear on reset, update at the end of the cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[r] <= '0;
            end else if (wen) begin
                regs[r] <= wval;
            end
        end
    end
endmodule

// File: rtl/tta_alu_unit.sv
// Integer ALU with operand, trigger and result registers, one-cycle latency.
// Assumes an operand moved with a trigger in the same instruction is used.
module tta_alu_unit
    import tta_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  move_t             mv [NSLOT],
    output logic [DATA_W-1:0] result,
    output logic              trig_fire
);
    logic [DATA_W-1:0] opnd_q, opnd_d, res_q, res_d, trig_val;
    alu_op_e           trig_op;

    // Port decode: later slots override earlier ones on both ports.
    always_comb begin
        opnd_d    = opnd_q;
        trig_fire = 1'b0;
        trig_val  = '0;
        trig_op   = OP_ADD;
        for (int s = 0; s < NSLOT; s++) begin
            if (mv[s].en && mv[s].dst == DST_OPND) begin
                opnd_d = mv[s].val;
            end
            if (mv[s].en && mv[s].dst[DST_W-1:3] == DST_TRIG_H) begin
                trig_fire = 1'b1;
                trig_val  = mv[s].val;
                trig_op   = alu_op_e'(mv[s].dst[2:0]);
            end
        end
    end

    // Operation: combine operand and trigger value.
    always_comb begin
        case (trig_op)
            OP_ADD:  res_d = opnd_d + trig_val;
            OP_SUB:  res_d = opnd_d - trig_val;
            OP_AND:  res_d = opnd_d & trig_val;
            OP_OR:   res_d = opnd_d | trig_val;
            OP_XOR:  res_d = opnd_d ^ trig_val;
            OP_EQ:   res_d = {{(DATA_W-1){1'b0}}, opnd_d == trig_val};
            OP_LTU:  res_d = {{(DATA_W-1){1'b0}}, opnd_d < trig_val};
            default: res_d = opnd_d << trig_val[4:0];
        endcase
    end

    // Registers: operand latches on any operand move, result only on trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
            res_q  <= '0;
        end else begin
            opnd_q <= opnd_d;
            if (trig_fire) begin
                res_q <= res_d;
            end
        end
    end

    assign result = res_q;
endmodule

// File: rtl/tta_core.sv
// Top: fetches one instruction per cycle, runs four move slots in parallel,
// and owns the PC, boolean guard registers and output port.
// Assumes instruction memory is loaded while rst_n is low.
module tta_core
    import tta_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imem_we,
    input  logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_wdata,
    output logic [PC_W-1:0]    pc,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data
);
    logic [INSTR_W-1:0] instr;
    logic [DATA_W-1:0]  limm, link, alu_res;
    logic [RADDR_W-1:0] rf_raddr [NSLOT];
    logic [DATA_W-1:0]  rf_rdata [NSLOT];
    move_t              mv       [NSLOT];
    logic [PC_W-1:0]    pc_d;
    logic [NBOOL-1:0]   bool_q, bool_d;
    logic               out_d;
    logic [DATA_W-1:0]  out_val_d;
    logic               ctrl_any, bool_any, out_any, trig_any;

    tta_imem #(.DEPTH(IMEM_DEPTH)) u_imem (
        .clk(clk), .we(imem_we), .waddr(imem_addr), .wdata(imem_wdata),
        .raddr(pc), .rdata(instr)
    );

    assign limm = instr[INSTR_W-1 -: DATA_W];
    assign link = DATA_W'(pc + 1'b1);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        tta_slot_unit u_slot (
            .slot(instr[s*SLOT_W +: SLOT_W]), .limm(limm), .link(link),
            .alu_res(alu_res), .bools(bool_q), .rf_rdata(rf_rdata[s]),
            .rf_raddr(rf_raddr[s]), .mv(mv[s])
        );
    end

    tta_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .raddr(rf_raddr), .rdata(rf_rdata), .mv(mv)
    );

    tta_alu_unit u_alu (
        .clk(clk), .rst_n(rst_n), .mv(mv), .result(alu_res), .trig_fire(trig_any)
    );

    // Control, guard and output sockets: highest executing slot wins.
    always_comb begin
        pc_d      = pc + 1'b1;
        bool_d    = bool_q;
        out_d     = 1'b0;
        out_val_d = out_data;
        ctrl_any  = 1'b0;
        bool_any  = 1'b0;
        out_any   = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (mv[s].en) begin
                if (mv[s].dst == DST_JUMP) begin
                    pc_d     = mv[s].val[PC_W-1:0];
                    ctrl_any = 1'b1;
                end else if (mv[s].dst == DST_BRANCH) begin
                    pc_d     = pc + mv[s].val[PC_W-1:0];
                    ctrl_any = 1'b1;
                end else if (mv[s].dst[DST_W-1:3] == DST_BOOL_H) begin
                    bool_d[mv[s].dst[BSEL_W-1:0]] = |mv[s].val;
                    bool_any = 1'b1;
                end else if (mv[s].dst == DST_OUT) begin
                    out_d     = 1'b1;
                    out_val_d = mv[s].val;
                    out_any   = 1'b1;
                end
            end
        end
    end

    // State update: PC, guard registers and the output port register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc        <= '0;
            bool_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            pc        <= pc_d;
            bool_q    <= bool_d;
            out_valid <= out_d;
            out_data  <= out_val_d;
        end
    end
endmodule

// File: rtl/tta_core_chk.sv
// Checker: temporal properties of the core's control and socket state.
// Assumes it is bound into tta_core and sees its internal move summaries.
module tta_core_chk #(
    parameter int PC_W = 6,
    parameter int DW   = 32,
    parameter int NB   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pc,
    input logic            out_valid,
    input logic [DW-1:0]   alu_res,
    input logic [NB-1:0]   bools,
    input logic            ctrl_any,
    input logic            trig_any,
    input logic            bool_any,
    input logic            out_any
);
    logic armed;

    // Arms the history-based checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !out_valid));

    assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(trig_any) |-> $stable(alu_res));

    assert_guard_regs_held_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(bool_any) |-> $stable(bools));

    assert_pc_sequential_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(ctrl_any) |-> (pc == PC_W'($past(pc) + 1'b1)));

    assert_out_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        out_valid |-> $past(out_any));
endmodule

bind tta_core tta_core_chk #(.PC_W(PC_W), .DW(tta_pkg::DATA_W), .NB(tta_pkg::NBOOL)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc(pc), .out_valid(out_valid), .alu_res(alu_res),
    .bools(bool_q), .ctrl_any(ctrl_any), .trig_any(trig_any),
    .bool_any(bool_any), .out_any(out_any)
);

// File: tb/tta_core_bench.sv
// Directed bench: each task loads a move program, runs it and checks the
// output-port trace, its timing and the final PC.
module tta_core_bench;
    localparam int IW = 100;
    localparam int AW = 6;

    localparam logic [5:0] S_RES = 6'h10, S_LIMM = 6'h11, S_LINK = 6'h12;
    localparam logic [5:0] D_OPND = 6'h10, D_ADD = 6'h18, D_SUB = 6'h19, D_AND = 6'h1A;
    localparam logic [5:0] D_XOR = 6'h1C, D_EQ = 6'h1D, D_SHL = 6'h1F;
    localparam logic [5:0] D_B3 = 6'h23, D_B4 = 6'h24;
    localparam logic [5:0] D_JMP = 6'h28, D_BR = 6'h29, D_OUT = 6'h2A;
    localparam logic [3:0] G_AL = 4'h0, G_NV = 4'h2, G_B3 = 4'hB, G_B4 = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          imem_we = 1'b0;
    logic [AW-1:0] imem_addr = '0;
    logic [IW-1:0] imem_wdata = '0;
    logic [AW-1:0] pc;
    logic          out_valid;
    logic [31:0]   out_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [IW-1:0] prog [32];
    int            plen;
    logic [31:0]   got_d [32];
    int            got_c [32];
    int            ng;

    tta_core u_tta_core (
        .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .pc(pc), .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [16:0] mv(input logic [3:0] g, input logic i,
                                       input logic [5:0] s, input logic [5:0] d);
        return {g, i, s, d};
    endfunction
    function automatic logic [16:0] mi(input logic [5:0] v, input logic [5:0] d);
        return {G_AL, 1'b1, v, d};
    endfunction
    function automatic logic [16:0] nop();
        return {G_NV, 1'b0, 6'h0, 6'h0};
    endfunction
    function automatic logic [IW-1:0] ins(input logic [16:0] s0, input logic [16:0] s1,
                                          input logic [16:0] s2, input logic [16:0] s3,
                                          input logic [31:0] l);
        return {l, s3, s2, s1, s0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 32; i++) prog[i] = ins(nop(), nop(), nop(), nop(), 32'h0);
        plen = 0;
    endtask

    // Loads prog[] under reset, runs ncyc cycles, logs output pulses.
    task automatic run(input int ncyc);
        rst_n = 1'b0;
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_addr = AW'(i); imem_wdata = prog[i];
        end
        @(negedge clk);
        imem_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ng = 0;
        for (int k = 1; k <= ncyc; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (out_valid && ng < 32) begin
                got_d[ng] = out_data; got_c[ng] = k; ng++;
            end
        end
    endtask

    task automatic t_reset();
        clear_prog();
        prog[0] = ins(mv(G_AL, 1'b0, S_RES, D_OUT), nop(), nop(), nop(), 0);
        prog[1] = ins(nop(), mv(G_B3, 1'b1, 6'd5, D_OUT), nop(), nop(), 0);
        prog[2] = ins(mi(6'd2, D_JMP), nop(), nop(), nop(), 0);
        plen = 3;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pc in reset", 32'(pc), 0);
        check("R1 out_valid in reset", 32'(out_valid), 0);
        run(8);
        check("R1 single output from reset-state program", ng, 1);
        check("R1 ALU result after reset", got_d[0], 0);
        check("R12 output pulse cycle", got_c[0], 1);
        check("R9 self jump pc", 32'(pc), 2);
    endtask

    task automatic t_imm();
        clear_prog();
        prog[0] = ins(nop(), nop(), mi(6'h3D, D_OUT), nop(), 0);
        prog[1] = ins(nop(), nop(), nop(), mv(G_AL, 1'b0, S_LIMM, D_OUT), 32'hDEADBEEF);
        prog[2] = ins(nop(), mi(6'd31, D_OUT), nop(), nop(), 0);
        prog[3] = ins(nop(), nop(), nop(), mv(G_AL, 1'b0, 6'h3E, D_OUT), 0);
        prog[4] = ins(mi(6'd4, D_JMP), nop(), nop(), nop(), 0);
        plen = 5;
        run(10);
        check("R2 output count", ng, 4);
        check("R3 negative short immediate", got_d[0], 32'hFFFFFFFD);
        check("R4 long immediate", got_d[1], 32'hDEADBEEF);
        check("R3 positive short immediate", got_d[2], 31);
        check("R4 unused source reads zero", got_d[3], 0);
    endtask

    task automatic t_rf();
        clear_prog();
        prog[0] = ins(mi(6'd7, 6'd1), mv(G_AL, 1'b0, S_LIMM, 6'd2), mi(6'h3F, 6'd15), nop(), 32'h12345678);
        prog[1] = ins(mv(G_AL, 1'b0, 6'd1, 6'd2), mv(G_AL, 1'b0, 6'd2, D_OUT), nop(), nop(), 0);
        prog[2] = ins(mv(G_AL, 1'b0, 6'd2, D_OUT), nop(), nop(), nop(), 0);
        prog[3] = ins(nop(), nop(), mv(G_AL, 1'b0, 6'd15, D_OUT), nop(), 0);
        prog[4] = ins(mi(6'd4, D_JMP), nop(), nop(), nop(), 0);
        plen = 5;
        run(10);
        check("R5 output count", ng, 3);
        check("R5 same-instruction read returns old value", got_d[0], 32'h12345678);
        check("R5 register copy visible next instruction", got_d[1], 7);
        check("R5 top register r15", got_d[2], 32'hFFFFFFFF);
    endtask

    task automatic t_alu();
        clear_prog();
        prog[0]  = ins(mi(6'd10, D_OPND), mi(6'd3, D_SUB), nop(), nop(), 0);
        prog[1]  = ins(mv(G_AL, 1'b0, S_RES, D_OUT), mi(6'd20, D_OPND), nop(), nop(), 0);
        prog[2]  = ins(mv(G_AL, 1'b0, S_RES, D_OUT), nop(), nop(), nop(), 0);
        prog[3]  = ins(mv(G_AL, 1'b0, S_LIMM, D_AND), nop(), nop(), nop(), 32'h0000F0F0);
        prog[5]  = ins(mv(G_AL, 1'b0, S_RES, D_OUT), nop(), nop(), nop(), 0);
        prog[6]  = ins(mi(6'd5, D_ADD), mv(G_AL, 1'b0, S_RES, D_OUT), nop(), nop(), 0);
        prog[7]  = ins(mv(G_AL, 1'b0, S_RES, D_OUT), nop(), nop(), nop(), 0);
        prog[8]  = ins(mi(6'd20, D_EQ), nop(), nop(), nop(), 0);
        prog[9]  = ins(mv(G_AL, 1'b0, S_RES, D_OUT), nop(), nop(), nop(), 0);
        prog[10] = ins(mi(6'h3F, D_XOR), nop(), nop(), nop(), 0);
        prog[11] = ins(mv(G_AL, 1'b0, S_RES, D_OUT), mi(6'd2, D_SHL), nop(), nop(), 0);
        prog[12] = ins(mv(G_AL, 1'b0, S_RES, D_OUT), nop(), nop(), nop(), 0);
        prog[13] = ins(mi(6'd13, D_JMP), nop(), nop(), nop(), 0);
        plen = 14;
        run(20);
        check("R6 output count", ng, 8);
        check("R6 sub with same-instruction operand", got_d[0], 7);
        check("R7 operand move leaves result", got_d[1], 7);
        check("R6 and, R7 held over idle cycle", got_d[2], 32'h10);
        check("R7 read in triggering instruction is old", got_d[3], 32'h10);
        check("R6 add", got_d[4], 25);
        check("R6 equal", got_d[5], 1);
        check("R6 xor", got_d[6], 32'hFFFFFFEB);
        check("R6 shift left", got_d[7], 80);
    endtask

    task automatic t_guard();
        clear_prog();
        prog[0] = ins(mi(6'd1, D_B3), mi(6'd0, D_B4), mv(G_B3, 1'b1, 6'd9, D_OUT), nop(), 0);
        prog[1] = ins(mv(G_B3, 1'b1, 6'd11, D_OUT), nop(), nop(), nop(), 0);
        prog[2] = ins(mv(G_B4, 1'b1, 6'd12, D_OUT), nop(), mv(4'h5, 1'b1, 6'd13, D_OUT), nop(), 0);
        prog[3] = ins(mv(G_B4, 1'b1, 6'd1, D_JMP), nop(), nop(), nop(), 0);
        prog[4] = ins(mi(6'd14, D_OUT), nop(), nop(), nop(), 0);
        prog[5] = ins(mi(6'd5, D_JMP), nop(), nop(), nop(), 0);
        plen = 6;
        run(12);
        check("R8 output count", ng, 2);
        check("R8 guard sees value after boolean write", got_d[0], 11);
        check("R8 guard timing", got_c[0], 2);
        check("R8 false-guarded jump ignored", got_d[1], 14);
    endtask

    task automatic t_ctrl();
        clear_prog();
        prog[0] = ins(mi(6'd3, D_JMP), nop(), nop(), nop(), 0);
        prog[1] = ins(mi(6'd1, D_OUT), nop(), nop(), nop(), 0);
        prog[2] = ins(mi(6'd1, D_OUT), nop(), nop(), nop(), 0);
        prog[3] = ins(mi(6'd2, D_OUT), mi(6'd2, D_BR), nop(), nop(), 0);
        prog[4] = ins(mi(6'd4, D_OUT), nop(), nop(), nop(), 0);
        prog[5] = ins(mi(6'd5, D_OUT), mv(G_AL, 1'b0, S_LINK, 6'd5), mi(6'd3, D_BR), nop(), 0);
        prog[6] = ins(mi(6'd6, D_OUT), nop(), nop(), nop(), 0);
        prog[7] = ins(mi(6'd0, D_BR), nop(), nop(), nop(), 0);
        prog[8] = ins(mi(6'd8, D_OUT), mv(G_AL, 1'b0, 6'd5, D_JMP), nop(), nop(), 0);
        plen = 9;
        run(12);
        check("R9 output count", ng, 4);
        check("R9 jump then branch", got_d[0], 2);
        check("R9 branch target", got_d[1], 5);
        check("R10 call target", got_d[2], 8);
        check("R10 return lands after call", got_d[3], 6);
        check("R12 pulse cycle after call", got_c[2], 4);
        check("R12 pulse cycle after return", got_c[3], 5);
        check("R9 final pc", 32'(pc), 7);
    endtask

    task automatic t_prio();
        clear_prog();
        prog[0]  = ins(mi(6'd1, D_OUT), mi(6'd2, D_OUT), mi(6'd3, D_OUT), mi(6'd4, D_OUT), 0);
        prog[1]  = ins(mi(6'd5, 6'd3), nop(), nop(), mi(6'd6, 6'd3), 0);
        prog[2]  = ins(mv(G_AL, 1'b0, 6'd3, D_OUT), nop(), nop(), nop(), 0);
        prog[3]  = ins(nop(), mi(6'd10, D_JMP), mi(6'd2, D_BR), nop(), 0);
        prog[4]  = ins(mi(6'd9, D_OUT), nop(), nop(), nop(), 0);
        prog[5]  = ins(mi(6'd21, D_OUT), nop(), nop(), mv(G_NV, 1'b1, 6'd22, D_OUT), 0);
        prog[6]  = ins(mi(6'd6, D_JMP), nop(), nop(), nop(), 0);
        prog[10] = ins(mi(6'd10, D_JMP), nop(), nop(), nop(), 0);
        plen = 11;
        run(12);
        check("R11 output count", ng, 3);
        check("R11 highest slot wins output", got_d[0], 4);
        check("R11 highest slot wins register", got_d[1], 6);
        check("R11 branch in higher slot beats jump", got_d[2], 21);
        check("R11 final pc", 32'(pc), 6);
    endtask

    initial begin
        t_reset();
        t_imm();
        t_rf();
        t_alu();
        t_guard();
        t_ctrl();
        t_prio();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule